// File: doc/BRIEF.md
# Output Virtual-Channel Access Control

This block manages the output virtual channels (VCs) of one router output port and takes the place of a separate VC allocation stage. A packet is given an output VC only after its head flit has won switch arbitration. The binding happens in the same cycle the flit crosses the crossbar, so VC allocation adds no pipeline stage of its own. For each output VC the block keeps an access vector. This is a bit mask with one bit per input VC that can reach the port. A bit at 1 means that input VC may use the output VC. A bit at 0 means it is locked out.

Each output VC is one slot controlled by a two-state machine. The states are SLOT_OPEN, where the vector is all ones, and SLOT_BOUND, where the vector is one-hot on the owning input VC. There are three transitions:

- BIND moves SLOT_OPEN to SLOT_BOUND. It fires when a head flit without a tail is granted that slot.
- UNBIND moves SLOT_BOUND to SLOT_OPEN. It fires when the owner's tail flit passes.
- PASS keeps the slot in SLOT_OPEN. It fires when a single-flit packet (head and tail together) uses the slot.

Body and tail flits look up the slot their input VC owns. For every accepted flit the block outputs the output VC number that goes into the outgoing flit header. It also outputs a flag that tells request-gating logic whether any output VC is still free.

Top module: `otf_access_matrix`

## Requirements
- R1: After reset every access vector is all ones and `free_any` is 1.
- R2: `access_vec` bit `o*NIN + k` is the access bit of output VC `o` for input VC `k`, where `k = port*VCS_PER_PORT + vc`. A bit at 1 means accessible.
- R3: A head flit presented while at least one output VC is free is accepted in the same cycle. `out_valid` is 1 and `out_vcid` is the lowest-numbered free output VC.
- R4: From the clock edge that accepts a head flit that is not also a tail, the vector of the chosen output VC is one-hot on `sw_ivc`.
- R5: A non-tail body flit from an input VC that owns an output VC is accepted in the same cycle with `out_vcid` equal to that VC, and no vector changes.
- R6: A tail flit from the owning input VC is accepted with the owned VC number. From the next edge that VC's vector is all ones again.
- R7: A flit that is both head and tail takes the lowest-numbered free VC, and that VC's vector stays all ones.
- R8: `free_any` is 1 exactly when at least one output VC's vector is all ones.
- R9: A non-head flit from an input VC that owns no output VC gives `out_valid` 0 and changes no vector.
- R10: A head flit presented while no output VC is free gives `out_valid` 0 and changes no vector.
- R11: While `sw_valid` is 0, `out_valid` is 0 and no vector changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_valid | input | 1 | A flit that won switch arbitration crosses to this port this cycle |
| sw_ivc | input | IVC_W | Input VC index of that flit |
| sw_head | input | 1 | Flit is a packet head |
| sw_tail | input | 1 | Flit is a packet tail |
| out_valid | output | 1 | Flit is accepted and carries `out_vcid` |
| out_vcid | output | OVC_W | Output VC number to place in the outgoing header |
| free_any | output | 1 | At least one output VC is free |
| access_vec | output | OUT_VCS*NIN | Concatenated access vectors, output VC 0 in the low bits |

## Verification
The bench builds the block with four input ports, two VCs per port and two output VCs. This gives the eight-bit vectors and a port that can be fully occupied after just two head flits. With these values the bench can reach the case where both VCs are held and a third head is refused. It can also reach the lowest-free choice when only VC 1 is open, and single-flit packets that pass through an open slot. A behavioural model keeps one owner per output VC and is compared against all outputs on every cycle. The stimulus is a directed sequence followed by a pseudo-random mix of heads, bodies, tails and non-owner flits.

// File: rtl/otf_pkg.sv
package otf_pkg;

    typedef enum logic {
        SLOT_OPEN  = 1'b0,
        SLOT_BOUND = 1'b1
    } slot_state_e;

endpackage

// File: rtl/otf_vc_slot.sv
module otf_vc_slot
    import otf_pkg::*;
#(
    parameter int NIN   = 8,
    parameter int IVC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim,
    input  logic             rel,
    input  logic [IVC_W-1:0] claim_ivc,
    input  logic [IVC_W-1:0] query_ivc,
    output logic             is_open,
    output logic             is_hit,
    output logic [NIN-1:0]   vec
);

    localparam logic [NIN-1:0] ONE = NIN'(1);

    slot_state_e      state_q, state_d;
    logic [IVC_W-1:0] owner_q;

    // next state: BIND, UNBIND, PASS
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_OPEN: begin
                if (claim && !rel) state_d = SLOT_BOUND;  // BIND
                else               state_d = SLOT_OPEN;   // PASS or stay
            end
            SLOT_BOUND: begin
                if (rel) state_d = SLOT_OPEN;              // UNBIND
            end
            default: state_d = SLOT_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_OPEN;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            if (claim && !rel) owner_q <= claim_ivc;
        end
    end

    always_comb begin
        is_open = 1'b0;
        is_hit  = 1'b0;
        vec     = '1;
        unique case (state_q)
            SLOT_OPEN: begin
                is_open = 1'b1;
                vec     = '1;
            end
            SLOT_BOUND: begin
                is_hit = (owner_q == query_ivc);
                vec    = ONE << owner_q;
            end
            default: vec = '1;
        endcase
    end

    // R3
    bind_only_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (state_q == SLOT_OPEN));

    // R4
    bind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !rel) |=> (vec == (ONE << $past(claim_ivc))));

    // R6
    unbind_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !claim) |=> (vec == '1));

    // R7
    pass_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && rel) |=> is_open);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim && !rel && state_q == SLOT_BOUND) |=> $stable(vec));

endmodule

// File: rtl/otf_vc_pick.sv
module otf_vc_pick #(
    parameter int OUT_VCS = 2,
    parameter int OVC_W   = 1
) (
    input  logic               want_head,
    input  logic [OUT_VCS-1:0] open_v,
    input  logic [OUT_VCS-1:0] hit_v,
    output logic               found,
    output logic [OVC_W-1:0]   sel_idx,
    output logic [OUT_VCS-1:0] sel_oh
);

    logic [OUT_VCS-1:0] cand;

    always_comb begin
        cand    = want_head ? open_v : hit_v;
        found   = |cand;
        sel_idx = '0;
        sel_oh  = '0;
        for (int i = OUT_VCS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                sel_idx = OVC_W'(i);
                sel_oh  = OUT_VCS'(1) << i;
            end
        end
    end

endmodule

// File: rtl/otf_access_matrix.sv
module otf_access_matrix #(
    parameter int IN_PORTS     = 4,
    parameter int VCS_PER_PORT = 2,
    parameter int OUT_VCS      = 2,
    localparam int NIN   = IN_PORTS * VCS_PER_PORT,
    localparam int IVC_W = (NIN > 1) ? $clog2(NIN) : 1,
    localparam int OVC_W = (OUT_VCS > 1) ? $clog2(OUT_VCS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sw_valid,
    input  logic [IVC_W-1:0]       sw_ivc,
    input  logic                   sw_head,
    input  logic                   sw_tail,
    output logic                   out_valid,
    output logic [OVC_W-1:0]       out_vcid,
    output logic                   free_any,
    output logic [OUT_VCS*NIN-1:0] access_vec
);

    logic [OUT_VCS-1:0] open_v, hit_v, sel_oh, claim_v, rel_v;
    logic               found;
    logic [OVC_W-1:0]   sel_idx;

    otf_vc_pick #(.OUT_VCS(OUT_VCS), .OVC_W(OVC_W)) i_pick (
        .want_head (sw_head),
        .open_v    (open_v),
        .hit_v     (hit_v),
        .found     (found),
        .sel_idx   (sel_idx),
        .sel_oh    (sel_oh)
    );

    for (genvar o = 0; o < OUT_VCS; o++) begin : g_slot
        assign claim_v[o] = sw_valid && sw_head && sel_oh[o];
        assign rel_v[o]   = sw_valid && sw_tail && sel_oh[o];

        otf_vc_slot #(.NIN(NIN), .IVC_W(IVC_W)) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim     (claim_v[o]),
            .rel       (rel_v[o]),
            .claim_ivc (sw_ivc),
            .query_ivc (sw_ivc),
            .is_open   (open_v[o]),
            .is_hit    (hit_v[o]),
            .vec       (access_vec[o*NIN +: NIN])
        );
    end

    assign out_valid = sw_valid && found;
    assign out_vcid  = sel_idx;
    assign free_any  = |open_v;

    // R3
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_v | rel_v));

    // R10
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_head && !free_any) |-> !out_valid);

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_valid |=> $stable(access_vec));

    // R8
    last_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sw_head && !sw_tail && $countones(open_v) == 1) |=> !free_any);

    // R9
    stray_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && !sw_head && hit_v == '0) |=> $stable(access_vec));

endmodule

// File: tb/test_otf_access_matrix.sv
`timescale 1ns/1ps
module test_otf_access_matrix;

    localparam int IN_PORTS = 4, VCS_PER_PORT = 2, OUT_VCS = 2;
    localparam int NIN = IN_PORTS * VCS_PER_PORT;
    localparam int IVC_W = 3, OVC_W = 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, sw_valid, sw_head, sw_tail;
    logic [IVC_W-1:0] sw_ivc;
    logic out_valid, free_any;
    logic [OVC_W-1:0] out_vcid;
    logic [OUT_VCS*NIN-1:0] access_vec;

    otf_access_matrix #(.IN_PORTS(IN_PORTS), .VCS_PER_PORT(VCS_PER_PORT), .OUT_VCS(OUT_VCS))
    i_otf_access_matrix (
        .clk(clk), .rst_n(rst_n), .sw_valid(sw_valid), .sw_ivc(sw_ivc),
        .sw_head(sw_head), .sw_tail(sw_tail), .out_valid(out_valid),
        .out_vcid(out_vcid), .free_any(free_any), .access_vec(access_vec)
    );

    int n_run = 0, n_fail = 0;
    int owner [OUT_VCS];

    task automatic chk(string tag, string what, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic longint model_vec();
        longint v = 0;
        for (int o = 0; o < OUT_VCS; o++) begin
            longint m = (owner[o] < 0) ? ((64'd1 << NIN) - 1) : (64'd1 << owner[o]);
            v |= m << (o * NIN);
        end
        return v;
    endfunction

    function automatic int model_free();
        for (int o = 0; o < OUT_VCS; o++) if (owner[o] < 0) return 1;
        return 0;
    endfunction

    function automatic int lowest_free();
        for (int o = 0; o < OUT_VCS; o++) if (owner[o] < 0) return o;
        return -1;
    endfunction

    function automatic int owned_by(int ivc);
        for (int o = 0; o < OUT_VCS; o++) if (owner[o] == ivc) return o;
        return -1;
    endfunction

    task automatic look(string tag);
        @(negedge clk);
        sw_valid = 1'b0; sw_head = 1'b0; sw_tail = 1'b0;
        #1;
        chk(tag, "access_vec", longint'(access_vec), model_vec());
        chk(tag, "free_any", longint'(free_any), longint'(model_free()));
    endtask

    task automatic step(bit v, int ivc, bit h, bit t);
        int sel;
        string tag;
        @(negedge clk);
        sw_valid = v; sw_ivc = IVC_W'(ivc); sw_head = h; sw_tail = t;
        #1;
        sel = !v ? -1 : (h ? lowest_free() : owned_by(ivc));
        if (!v)                       tag = "R11";
        else if (h && sel < 0)        tag = "R10";
        else if (h && t)              tag = "R7";
        else if (h)                   tag = "R3";
        else if (sel < 0)             tag = "R9";
        else if (t)                   tag = "R6";
        else                          tag = "R5";
        chk(tag, "out_valid", longint'(out_valid), longint'(sel >= 0));
        if (sel >= 0) chk(tag, "out_vcid", longint'(out_vcid), longint'(sel));
        chk("R8", "free_any", longint'(free_any), longint'(model_free()));
        chk("R2", "access_vec", longint'(access_vec), model_vec());
        @(posedge clk);
        if (sel >= 0) begin
            if (h && !t) owner[sel] = ivc;
            else if (!h && t) owner[sel] = -1;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int o = 0; o < OUT_VCS; o++) owner[o] = -1;
        rst_n = 1'b0; sw_valid = 1'b0; sw_ivc = '0; sw_head = 1'b0; sw_tail = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        look("R1");
        step(0, 0, 0, 0);            // R11 idle
        step(1, 5, 1, 0);            // R3 head on VC0
        look("R4");                  // vector 0 one-hot on input VC 5
        step(1, 5, 0, 0);            // R5 body
        step(1, 1, 1, 0);            // R3 head on VC1, port now full
        look("R8");
        step(1, 3, 1, 0);            // R10 refused
        step(1, 3, 0, 0);            // R9 stray body
        step(1, 3, 0, 1);            // R9 stray tail
        step(1, 5, 0, 1);            // R6 tail frees VC0
        look("R6");
        step(1, 7, 1, 1);            // R7 single flit through VC0
        look("R7");
        step(1, 1, 0, 1);            // R6 tail frees VC1
        step(1, 2, 1, 0);            // R3 lowest free
        step(1, 4, 1, 1);            // R7 when only VC1 open
        step(1, 2, 0, 1);
        for (int n = 0; n < 600; n++) begin
            int ivc = $urandom_range(0, NIN - 1);
            int k = $urandom_range(0, 9);
            if (k == 0)                 step(0, ivc, 0, 0);
            else if (owned_by(ivc) >= 0) step(1, ivc, 0, ($urandom_range(0, 3) == 0));
            else if (k == 1)            step(1, ivc, 0, ($urandom_range(0, 1) == 0));
            else                        step(1, ivc, 1, ($urandom_range(0, 4) == 0));
        end
        look("R2");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule